// File: doc/BRIEF.md
# Asynchronous SRAM Device Responder

This block is a clocked, synthesizable stand-in for a byte-wide asynchronous static RAM. A bus master drives two chip selects (one active low, one active high), an active-low write strobe, an active-low output enable, an address and a write data byte. Each clock the responder decodes these pins into one of four modes: standby, idle-active, write or read. It stores written bytes in a memory that maps onto block RAM. It drives read data once the read has been held long enough, and it releases its output bus whenever it is not reading.

Read data is held back for a configurable number of clocks. The count runs from the first cycle of a read at a given address, and any change of address, or any break in the read, starts it again. Until the count is reached, a valid flag stays low and the data lines show zero, so old data never appears on them. Alongside the data the block reports three status bits for power accounting. One marks standby, one marks an enabled chip, and one marks a page hit: a read that follows another read within the same 16-word page. The address bits above the word field identify the page.

All outputs are registered and reflect the pins sampled at the previous rising edge. The default address width is kept small, and setting `ADDR_W` to 17 gives the full 128K-byte organisation.

Top module: `sram_responder`

## Requirements
- R1: When `ce1_n` is 1 or `ce2` is 0, the next cycle shows `st_standby`=1, `st_active`=0, `data_oe`=0, `rd_valid`=0 and `page_hit`=0. Write strobe, enable, address and data have no effect, so no memory byte changes.
- R2: When `ce1_n`=0, `ce2`=1 and `we_n`=0, the byte on `wr_data` is stored at `addr` whatever `oe_n` is, and the next cycle shows `data_oe`=0.
- R3: When `ce1_n`=0, `ce2`=1, `we_n`=1 and `oe_n`=1, the next cycle shows `data_oe`=0 with `st_active`=1 and `st_standby`=0.
- R4: When `ce1_n`=0, `ce2`=1, `we_n`=1 and `oe_n`=0 (a read), the next cycle shows `data_oe`=1.
- R5: `rd_valid` is 1 in the cycle after the READ_LAT-th consecutive read cycle at one address, and it stays 1 while that read is held. While it is 1, `rd_data` shows the stored byte. While it is 0, `rd_data` is 0.
- R6: A read whose address differs from the previous cycle's, or which follows a non-read cycle, restarts the latency count. With READ_LAT > 1, `rd_valid` is then 0 in the next cycle.
- R7: A read of an address written in the immediately preceding cycle returns the newly written byte.
- R8: `page_hit` is 1 in the cycle after a read whose previous cycle was also a read with equal address bits [ADDR_W-1:4]. The word bits [3:0] may differ.
- R9: `page_hit` is 0 after a read that follows an `oe_n`=1 cycle, a write, a standby cycle, or a read in a different page.
- R10: During and right after synchronous reset, `st_standby`=1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, zero while not valid |
| data_oe | output | 1 | Output driver enable (1 = driving, 0 = high impedance) |
| rd_valid | output | 1 | Read data has met its latency |
| st_standby | output | 1 | Chip deselected in previous cycle |
| st_active | output | 1 | Chip selected in previous cycle |
| page_hit | output | 1 | Read stayed in the open page |

## Verification
The assertions check the mode decode on every cycle. Standby silences every output, a write or an idle-active cycle releases the bus, and a read drives it. They also check that a valid flag or a page hit never appears without a driven bus, and that an address change mid-read clears the valid flag. Several things can only be shown by the bench scenarios. These are the stored byte contents, the exact cycle on which data becomes valid, write-then-read freshness, and that writes attempted in standby leave memory untouched. They also include page-hit sequences across word changes, page changes and enable breaks.

// File: rtl/sram_resp_pkg.sv
package sram_resp_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_READ    = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/sram_resp_decode.sv
module sram_resp_decode
  import sram_resp_pkg::*;
(
  input  logic      ce1_n,
  input  logic      ce2,
  input  logic      we_n,
  input  logic      oe_n,
  output acc_mode_e mode
);
  logic selected;
  assign selected = !ce1_n && ce2;

  // Deselect wins over everything; the write strobe masks output enable.
  always_comb begin
    if (!selected)      mode = MODE_STANDBY;
    else if (!we_n)     mode = MODE_WRITE;
    else if (!oe_n)     mode = MODE_READ;
    else                mode = MODE_IDLE;
  end
endmodule

// File: rtl/sram_resp_array.sv
module sram_resp_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single-port, synchronous read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
    if (rd_en) rd_q <= mem[addr];
  end
endmodule

// File: rtl/sram_resp_latency.sv
module sram_resp_latency #(
  parameter int ADDR_W   = 10,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_valid
);
  generate
    if (READ_LAT <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_req;
      end
    end else begin : g_count
      localparam int CNT_W = $clog2(READ_LAT + 1);
      localparam logic [CNT_W-1:0] LAT_C = CNT_W'(READ_LAT);

      logic              prev_rd;
      logic [ADDR_W-1:0] prev_addr;
      logic [CNT_W-1:0]  run_cnt;
      logic [CNT_W-1:0]  run_nxt;
      logic              same;

      assign same = prev_rd && (addr == prev_addr);

      always_comb begin
        if (!rd_req)                run_nxt = '0;
        else if (!same)             run_nxt = CNT_W'(1);
        else if (run_cnt >= LAT_C)  run_nxt = LAT_C;
        else                        run_nxt = run_cnt + CNT_W'(1);
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          prev_rd   <= 1'b0;
          prev_addr <= '0;
          run_cnt   <= '0;
          rd_valid  <= 1'b0;
        end else begin
          prev_rd   <= rd_req;
          prev_addr <= addr;
          run_cnt   <= run_nxt;
          rd_valid  <= rd_req && (run_nxt >= LAT_C);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sram_resp_page.sv
module sram_resp_page #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  output logic              page_hit
);
  localparam int PAGE_W = ADDR_W - WORD_W;

  logic              prev_rd;
  logic [PAGE_W-1:0] prev_page;
  logic [PAGE_W-1:0] cur_page;

  assign cur_page = addr[ADDR_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rd   <= 1'b0;
      prev_page <= '0;
      page_hit  <= 1'b0;
    end else begin
      prev_rd   <= rd_req;
      prev_page <= cur_page;
      page_hit  <= rd_req && prev_rd && (cur_page == prev_page);
    end
  end
endmodule

// File: rtl/sram_responder.sv
module sram_responder
  import sram_resp_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int WORD_W   = 4,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_oe,
  output logic              rd_valid,
  output logic              st_standby,
  output logic              st_active,
  output logic              page_hit
);
  acc_mode_e         mode;
  logic              is_rd;
  logic              is_wr;
  logic [DATA_W-1:0] rd_q;

  sram_resp_decode u_decode (
    .ce1_n (ce1_n),
    .ce2   (ce2),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .mode  (mode)
  );

  assign is_rd = (mode == MODE_READ);
  assign is_wr = (mode == MODE_WRITE);

  sram_resp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (is_wr),
    .rd_en   (is_rd),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_q    (rd_q)
  );

  sram_resp_latency #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) u_latency (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (is_rd),
    .addr     (addr),
    .rd_valid (rd_valid)
  );

  sram_resp_page #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_page (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (is_rd),
    .addr     (addr),
    .page_hit (page_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_standby <= 1'b1;
      st_active  <= 1'b0;
      data_oe    <= 1'b0;
    end else begin
      st_standby <= (mode == MODE_STANDBY);
      st_active  <= (mode != MODE_STANDBY);
      data_oe    <= is_rd;
    end
  end

  // Data lines carry zero until the read has met its latency.
  assign rd_data = rd_valid ? rd_q : '0;
endmodule

// File: rtl/sram_responder_checker.sv
module sram_responder_checker #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int READ_LAT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ce1_n,
  input logic              ce2,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              data_oe,
  input logic              rd_valid,
  input logic              st_standby,
  input logic              st_active,
  input logic              page_hit
);
  logic sel;
  logic rd_pin;
  assign sel    = !ce1_n && ce2;
  assign rd_pin = sel && we_n && !oe_n;

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (st_standby && !st_active && !data_oe && !rd_valid && !page_hit));

  assert_write_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (sel && !we_n) |=> !data_oe);

  assert_idle_active_R3: assert property (@(posedge clk) disable iff (rst)
    (sel && we_n && oe_n) |=> (st_active && !st_standby && !data_oe));

  assert_read_drive_R4: assert property (@(posedge clk) disable iff (rst)
    rd_pin |=> data_oe);

  assert_valid_driven_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> data_oe);

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    ((READ_LAT > 1) && rd_pin && (addr != $past(addr))) |=> !rd_valid);

  assert_hit_driven_R8: assert property (@(posedge clk) disable iff (rst)
    page_hit |-> data_oe);
endmodule

bind sram_responder sram_responder_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(READ_LAT)
) u_checker (
  .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n),
  .addr(addr), .rd_data(rd_data), .data_oe(data_oe), .rd_valid(rd_valid),
  .st_standby(st_standby), .st_active(st_active), .page_hit(page_hit)
);

// File: tb/sram_responder_test.sv
module sram_responder_test;
  localparam int AW  = 10;
  localparam int DW  = 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n = 1'b1, ce2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic data_oe, rd_valid, st_standby, st_active, page_hit;

  always #2 clk = ~clk;

  sram_responder #(.ADDR_W(AW), .DATA_W(DW), .WORD_W(4), .READ_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .data_oe(data_oe),
    .rd_valid(rd_valid), .st_standby(st_standby), .st_active(st_active),
    .page_hit(page_hit)
  );

  typedef struct {
    logic          oe;
    logic          vld;
    logic [DW-1:0] dout;
    logic          sb;
    logic          act;
    logic          hit;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state, derived from the requirements
  logic [DW-1:0] ref_mem [int];
  logic          m_prev_rd = 0;
  logic [AW-1:0] m_prev_addr = '0;
  int            m_cnt = 0;

  task automatic step(input string tag, input logic c1, input logic c2,
                      input logic w, input logic o, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    exp_t e;
    logic en, wr, rd, same;
    int nxt;
    @(negedge clk);
    ce1_n = c1; ce2 = c2; we_n = w; oe_n = o; addr = a; wr_data = d;
    en = !c1 && c2;
    wr = en && !w;
    rd = en && w && !o;
    same = m_prev_rd && (a == m_prev_addr);
    nxt = !rd ? 0 : (!same ? 1 : ((m_cnt + 1 > LAT) ? LAT : m_cnt + 1));
    e.oe   = rd;
    e.vld  = rd && (nxt >= LAT);
    e.dout = (e.vld && ref_mem.exists(int'(a))) ? ref_mem[int'(a)] : '0;
    e.sb   = !en;
    e.act  = en;
    e.hit  = rd && m_prev_rd && (a[AW-1:4] == m_prev_addr[AW-1:4]);
    e.tag  = tag;
    exp_q.push_back(e);
    if (wr) ref_mem[int'(a)] = d;
    m_prev_rd = rd;
    m_prev_addr = a;
    m_cnt = nxt;
  endtask

  task automatic wr_b(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(tag, 1'b0, 1'b1, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd_b(input string tag, input logic [AW-1:0] a);
    step(tag, 1'b0, 1'b1, 1'b1, 1'b0, a, 8'h00);
  endtask

  // monitor: pops one expected item per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compared++;
        if (data_oe !== e.oe || rd_valid !== e.vld || rd_data !== e.dout ||
            st_standby !== e.sb || st_active !== e.act || page_hit !== e.hit) begin
          mismatched++;
          $display("FAIL %s: actual oe=%b vld=%b dout=%h sb=%b act=%b hit=%b expected oe=%b vld=%b dout=%h sb=%b act=%b hit=%b",
                   e.tag, data_oe, rd_valid, rd_data, st_standby, st_active, page_hit,
                   e.oe, e.vld, e.dout, e.sb, e.act, e.hit);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    compared++;
    if (data_oe !== 0 || rd_valid !== 0 || rd_data !== 0 || st_standby !== 1 ||
        st_active !== 0 || page_hit !== 0) begin
      mismatched++;
      $display("FAIL R10: actual oe=%b vld=%b dout=%h sb=%b act=%b hit=%b expected 0 0 00 1 0 0",
               data_oe, rd_valid, rd_data, st_standby, st_active, page_hit);
    end

    step("R1 idle standby", 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 8'h00);
    // R2: writes, one with oe_n low (write priority)
    wr_b("R2 write", 10'h010, 8'hA0);
    wr_b("R2 write", 10'h011, 8'hA1);
    step("R2 write with oe low", 1'b0, 1'b1, 1'b0, 1'b0, 10'h012, 8'hA2);
    wr_b("R2 write", 10'h013, 8'hA3);
    wr_b("R2 write", 10'h022, 8'hB2);
    // R3: enabled idle
    step("R3 idle active", 1'b0, 1'b1, 1'b1, 1'b1, 10'h012, 8'h00);
    // R4 R5: held read
    rd_b("R4 read first", 10'h012);
    rd_b("R5 read valid", 10'h012);
    rd_b("R5 read held", 10'h012);
    rd_b("R5 read held", 10'h012);
    // R6: address change restarts latency; R8 same page hit
    rd_b("R6 restart", 10'h013);
    rd_b("R6 valid after restart", 10'h013);
    rd_b("R8 word change", 10'h010);
    rd_b("R8 word change", 10'h011);
    rd_b("R8 held", 10'h011);
    // R9: page change
    rd_b("R9 page change", 10'h022);
    rd_b("R9 new page held", 10'h022);
    // R9: oe break
    step("R9 oe break", 1'b0, 1'b1, 1'b1, 1'b1, 10'h022, 8'h00);
    rd_b("R9 after oe break", 10'h022);
    rd_b("R9 after oe break held", 10'h022);
    // R9: standby break
    step("R9 standby break", 1'b1, 1'b1, 1'b1, 1'b0, 10'h022, 8'h00);
    rd_b("R9 after standby", 10'h023);
    // R1: writes attempted while deselected by either select
    step("R1 ce1 high write", 1'b1, 1'b1, 1'b0, 1'b1, 10'h010, 8'hFF);
    step("R1 ce2 low write", 1'b0, 1'b0, 1'b0, 1'b0, 10'h011, 8'hEE);
    rd_b("R1 check 010", 10'h010);
    rd_b("R1 check 010 valid", 10'h010);
    rd_b("R1 check 011", 10'h011);
    rd_b("R1 check 011 valid", 10'h011);
    // R7: write then read immediately, also R9 write break
    wr_b("R7 overwrite", 10'h013, 8'h5C);
    rd_b("R7 read new", 10'h013);
    rd_b("R7 read new valid", 10'h013);
    // sweep across a page and into the next
    for (int i = 0; i < 20; i++) wr_b("R2 sweep write", 10'h100 + 10'(i), 8'(i * 7 + 3));
    for (int i = 0; i < 20; i++) begin
      rd_b("R5 sweep read", 10'h100 + 10'(i));
      rd_b("R8 sweep read held", 10'h100 + 10'(i));
    end
    step("R1 end standby", 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 8'h00);
    step("R1 end standby", 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 8'h00);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule